// File: doc/BRIEF.md
# One-Hot Byte Crossbar with Pipelined OR Reduction

This block gathers a wide output word from a bank of source bytes. Up to 240 source bytes arrive on a flat input bus. Each of 64 output lanes has its own select vector that holds one bit per source byte. A lane's output byte is made by gating every source byte with its select bit and then OR-ing the gated bytes together. Each lane chooses on its own, so any pattern of choices is legal, including several lanes that pick the same source byte.

The OR reduction is a tree. Each stage combines a parameterised number of inputs, and a register follows every stage, so the logic depth per cycle stays small however many sources there are. The inputs are captured in a register rank first. A valid flag travels through the same ranks, so the output flag marks the word that belongs to an earlier strobe. A stage's registers load only when a valid item enters that stage. Between results, the output word therefore holds its last value.

Top module: `xbar_onehot_top`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `outValid` is 0 and `outData` is all zeros.
- R2: When a lane's select vector has only bit i set, that lane's output byte equals source byte i. Lane j uses `laneSel[j*240 + i]`, source byte i sits on `srcBytes[8*i+7:8*i]`, and lane j drives `outData[8*j+7:8*j]`.
- R3: A lane whose select vector is all zeros outputs 0x00.
- R4: A lane whose select vector has several bits set outputs the bitwise OR of all the chosen source bytes.
- R5: With the default fan-in of 4, a word sampled at a rising edge with `inValid` high appears on `outData`, with `outValid` high, right after the fifth rising edge, counting the sampling edge as the first. That is one input rank plus ceil(log4(240)) = 4 tree ranks.
- R6: Inputs strobed on consecutive cycles produce results on consecutive cycles, each one correct and none lost or repeated.
- R7: While `inValid` is low, changes on `srcBytes` and `laneSel` have no effect. `outValid` stays low once the pipeline drains, and `outData` holds the last result.
- R8: Lanes are independent. Any number of lanes may select the same source byte at the same time.
- R9: Every source index from 0 through 239 can be reached, including both ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks `srcBytes` and `laneSel` as a word to process this cycle |
| srcBytes | input | 1920 | Source bytes; byte i at bits 8i+7..8i |
| laneSel | input | 15360 | Per-lane select vectors; lane j at bits 240j+239..240j |
| outValid | output | 1 | High for one cycle per result |
| outData | output | 512 | Gathered word; lane j at bits 8j+7..8j |

## Verification
The bench looks for these corner cases:
- Lanes with empty select vectors. A design that mishandled the gating would leak a stray byte into them instead of 0x00.
- Lanes with several bits set. A design that treated the select as a priority multiplexer would return one byte instead of the OR.
- Broadcasts of source 0 and source 239 to every lane. These catch an off-by-one in the tree grouping or in the last, partly filled group.
- Back-to-back strobes and idle gaps filled with changing garbage. These expose a valid flag that slips against its data, and a stage that loads without a valid item, which would corrupt the held output.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  localparam int MAX_RANKS = 16;

  // Strobes from control to datapath: load[k] enables register rank k.
  typedef struct packed {
    logic [MAX_RANKS-1:0] load;
  } rankStrobes_t;

  // Number of entries left after lvl stages of fanIn-way reduction.
  function automatic int nodesAt(int total, int fanIn, int lvl);
    int n;
    n = total;
    for (int i = 0; i < MAX_RANKS; i++) begin
      if (i < lvl) n = (n + fanIn - 1) / fanIn;
    end
    return n;
  endfunction

  // Number of reduction stages needed to reach a single entry.
  function automatic int levelCount(int total, int fanIn);
    int n;
    int c;
    n = total;
    c = 0;
    for (int i = 0; i < MAX_RANKS; i++) begin
      if (n > 1) begin
        n = (n + fanIn - 1) / fanIn;
        c++;
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
#(
  parameter int LEVELS = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output rankStrobes_t strobes,
  output logic         outValid
);

  logic [LEVELS:0] vldPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vldPipe <= '0;
    else       vldPipe <= {vldPipe[LEVELS-1:0], inValid};
  end

  always_comb begin
    strobes = '0;
    strobes.load[0] = inValid;
    for (int k = 1; k <= LEVELS; k++) begin
      strobes.load[k] = vldPipe[k-1];
    end
  end

  assign outValid = vldPipe[LEVELS];

  // R1: nothing leaves the pipeline in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> !outValid);

endmodule

// File: rtl/xbar_dpath.sv
module xbar_dpath
  import xbar_pkg::*;
#(
  parameter int SRC_BYTES = 240,
  parameter int LANES     = 64,
  parameter int FANIN     = 4,
  parameter int LEVELS    = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  rankStrobes_t               strobes,
  input  logic [SRC_BYTES*8-1:0]     srcBytes,
  input  logic [LANES*SRC_BYTES-1:0] laneSel,
  output logic [LANES*8-1:0]         outData
);

  // Rank 0: captured sources and select vectors.
  logic [SRC_BYTES-1:0][7:0]      srcReg;
  logic [LANES-1:0][SRC_BYTES-1:0] selReg;

  logic unusedStrobes;
  assign unusedStrobes = ^strobes.load[MAX_RANKS-1:LEVELS+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcReg <= '0;
      selReg <= '0;
    end else if (strobes.load[0]) begin
      srcReg <= srcBytes;
      selReg <= laneSel;
    end
  end

  // Ranks 1..LEVELS: FANIN-way OR stages, the first fused with gating.
  for (genvar lvl = 1; lvl <= LEVELS; lvl++) begin : lvlG
    localparam int IN_N  = nodesAt(SRC_BYTES, FANIN, lvl - 1);
    localparam int OUT_N = nodesAt(SRC_BYTES, FANIN, lvl);

    logic [LANES-1:0][IN_N-1:0][7:0]  nodeIn;
    logic [LANES-1:0][OUT_N-1:0][7:0] nodeSum;
    logic [LANES-1:0][OUT_N-1:0][7:0] nodeQ;

    if (lvl == 1) begin : gateG
      always_comb begin
        for (int l = 0; l < LANES; l++) begin
          for (int s = 0; s < IN_N; s++) begin
            nodeIn[l][s] = srcReg[s] & {8{selReg[l][s]}};
          end
        end
      end

      // R3: an empty select group yields a zero first-stage node
      a_r3_zero_select_gates: assert property (@(posedge clk) disable iff (!rstN)
        (strobes.load[1] && selReg[0][FANIN-1:0] == '0) |=> (nodeQ[0][0] == 8'h00));
    end else begin : chainG
      assign nodeIn = lvlG[lvl-1].nodeQ;
    end

    always_comb begin
      for (int l = 0; l < LANES; l++) begin
        for (int n = 0; n < OUT_N; n++) begin
          nodeSum[l][n] = 8'h00;
          for (int f = 0; f < FANIN; f++) begin
            if (n * FANIN + f < IN_N) begin
              nodeSum[l][n] = nodeSum[l][n] | nodeIn[l][n * FANIN + f];
            end
          end
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   nodeQ <= '0;
      else if (strobes.load[lvl])  nodeQ <= nodeSum;
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      outData[l*8 +: 8] = lvlG[LEVELS].nodeQ[l][0];
    end
  end

endmodule

// File: rtl/xbar_onehot_top.sv
module xbar_onehot_top
  import xbar_pkg::*;
#(
  parameter int SRC_BYTES = 240,
  parameter int LANES     = 64,
  parameter int FANIN     = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [SRC_BYTES*8-1:0]     srcBytes,
  input  logic [LANES*SRC_BYTES-1:0] laneSel,
  output logic                       outValid,
  output logic [LANES*8-1:0]         outData
);

  localparam int LEVELS = levelCount(SRC_BYTES, FANIN);
  localparam int LAT    = LEVELS + 1;

  rankStrobes_t strobes;

  xbar_ctrl #(
    .LEVELS (LEVELS)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  xbar_dpath #(
    .SRC_BYTES (SRC_BYTES),
    .LANES     (LANES),
    .FANIN     (FANIN),
    .LEVELS    (LEVELS)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .srcBytes (srcBytes),
    .laneSel  (laneSel),
    .outData  (outData)
  );

  // Items accepted but not yet delivered.
  int inFlight;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inFlight <= 0;
    else       inFlight <= inFlight + (inValid ? 1 : 0) - (outValid ? 1 : 0);
  end

  // R6: the pipeline never holds more items than it has ranks
  a_r6_inflight_bound: assert property (@(posedge clk) disable iff (!rstN)
    (inFlight >= 0) && (inFlight <= LAT));

  // R7: the output word moves only together with a valid result
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outData) |-> outValid);

endmodule

// File: tb/xbar_onehot_top_tb_top.sv
module xbar_onehot_top_tb_top;

  localparam int SRC   = 240;
  localparam int LANES = 64;
  localparam int FAN   = 4;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   inValid = 1'b0;
  logic [SRC*8-1:0]       srcBytes = '0;
  logic [LANES*SRC-1:0]   laneSel = '0;
  logic                   outValid;
  logic [LANES*8-1:0]     outData;

  xbar_onehot_top #(.SRC_BYTES(SRC), .LANES(LANES), .FANIN(FAN)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcBytes(srcBytes),
    .laneSel(laneSel), .outValid(outValid), .outData(outData)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int lat;
  logic [LANES*8-1:0] expQ[$];
  int                 dueQ[$];
  string              tagQ[$];
  logic [LANES*8-1:0] lastExp = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int levelsFor(int n, int f);
    int c = 0;
    while (n > 1) begin
      n = (n + f - 1) / f;
      c++;
    end
    return c;
  endfunction

  // Reference: index the sources directly per lane.
  function automatic logic [LANES*8-1:0] refWord();
    logic [LANES*8-1:0] w;
    w = '0;
    for (int l = 0; l < LANES; l++) begin
      for (int s = 0; s < SRC; s++) begin
        if (laneSel[l*SRC + s]) w[l*8 +: 8] = w[l*8 +: 8] | srcBytes[s*8 +: 8];
      end
    end
    return w;
  endfunction

  task automatic checkCycle();
    checks++;
    if (dueQ.size() > 0 && dueQ[0] == cyc) begin
      if (outValid !== 1'b1 || outData !== expQ[0]) begin
        errors++;
        $display("FAIL %s/R5 cyc=%0d outValid=%b expected=1 outData=%h expected=%h",
                 tagQ[0], cyc, outValid, outData, expQ[0]);
      end
      lastExp = expQ[0];
      void'(expQ.pop_front());
      void'(dueQ.pop_front());
      void'(tagQ.pop_front());
    end else begin
      if (outValid !== 1'b0 || outData !== lastExp) begin
        errors++;
        $display("FAIL R7 hold cyc=%0d outValid=%b expected=0 outData=%h expected=%h",
                 cyc, outValid, outData, lastExp);
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    checkCycle();
  endtask

  task automatic randSrc();
    for (int i = 0; i < SRC / 4; i++) srcBytes[i*32 +: 32] = $urandom;
  endtask

  task automatic pushWord(string tag);
    inValid = 1'b1;
    expQ.push_back(refWord());
    dueQ.push_back(cyc + lat);
    tagQ.push_back(tag);
  endtask

  initial begin
    lat = levelsFor(SRC, FAN) + 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (outValid !== 1'b0 || outData !== '0) begin
      errors++;
      $display("FAIL R1 outValid=%b expected=0 outData=%h expected=0", outValid, outData);
    end

    // R2/R6: random one-hot selects, back to back
    for (int t = 0; t < 30; t++) begin
      randSrc();
      laneSel = '0;
      for (int l = 0; l < LANES; l++) laneSel[l*SRC + $urandom_range(0, SRC-1)] = 1'b1;
      pushWord("R2/R6");
      step();
    end

    // R7: idle gap with changing garbage
    inValid = 1'b0;
    for (int t = 0; t < 12; t++) begin
      randSrc();
      for (int i = 0; i < LANES*SRC/32; i++) laneSel[i*32 +: 32] = $urandom;
      step();
    end

    // R3: zero selects on every other lane
    for (int t = 0; t < 8; t++) begin
      randSrc();
      laneSel = '0;
      for (int l = 1; l < LANES; l += 2) laneSel[l*SRC + $urandom_range(0, SRC-1)] = 1'b1;
      pushWord("R3");
      step();
      inValid = 1'b0;
      step();
    end

    // R4: multi-hot selects, lane 0 selects everything
    for (int t = 0; t < 10; t++) begin
      randSrc();
      laneSel = '0;
      for (int l = 0; l < LANES; l++) begin
        for (int k = 0; k < 1 + (l % 4); k++) laneSel[l*SRC + $urandom_range(0, SRC-1)] = 1'b1;
      end
      laneSel[SRC-1:0] = '1;
      pushWord("R4");
      step();
    end

    // R8/R9: broadcast of both end indices to every lane
    for (int e = 0; e < 2; e++) begin
      randSrc();
      laneSel = '0;
      for (int l = 0; l < LANES; l++) laneSel[l*SRC + (e == 0 ? 0 : SRC-1)] = 1'b1;
      pushWord("R8/R9");
      step();
    end

    // R9: sweep of single-index selects, each lane picks (lane + offset)
    for (int t = 0; t < 4; t++) begin
      randSrc();
      laneSel = '0;
      for (int l = 0; l < LANES; l++) laneSel[l*SRC + ((l + t*LANES) % SRC)] = 1'b1;
      pushWord("R9");
      step();
    end

    // Drain, then confirm R7 hold and nothing pending
    inValid = 1'b0;
    for (int t = 0; t < lat + 4; t++) begin
      randSrc();
      step();
    end
    checks++;
    if (dueQ.size() != 0) begin
      errors++;
      $display("FAIL R6 pending results=%0d expected=0", dueQ.size());
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule